// File: doc/BRIEF.md
# Dual-Word Programmable Divide Counter

This block divides its clock by a programmable ratio. Two 8-bit divide words are kept in two holding registers, and each register has its own load strobe. A select input decides which held word the down counter takes as its reload value. The counter steps down once per enabled clock. When it reaches zero it reloads from the selected word on the next enabled clock, so the divide ratio is the selected word plus one. A terminal-count pulse marks each zero. The pulse is re-registered before it reaches the output.

Because each word has its own register, software or a control sequencer can write a new ratio into the idle register while the other register keeps driving the count. Flipping the select input then changes the modulus at the next reload boundary, with no glitch in the sequence that is running. The enable input stalls the whole block in place. A reset clears the counter and both words and drops the output.

The counter is a two-state machine. `ST_TERM` means the count is zero. `ST_DOWN` means the count is non-zero. The machine moves between them on enabled clocks only:
- TERM→TERM: the reload word is zero.
- TERM→DOWN: the reload word is non-zero.
- DOWN→DOWN: the count is above one.
- DOWN→TERM: the count is exactly one.

Top module: `divword_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the counter to zero, clears both held words to zero and drives `tc_out` low on the following cycle.
- R2: A holding register passes its input bus straight through while its load strobe is high, and that includes a reload taking place in the same cycle. On each clock edge with the strobe high it captures the bus. Once the strobe is low it keeps the captured value, whatever the bus does.
- R3: `word_sel` = 0 selects word A as the reload value, and `word_sel` = 1 selects word B.
- R4: On each enabled clock the counter steps down by one. On the enabled clock after it reaches zero, it loads the selected word. With word N selected, `tc_out` therefore repeats every N+1 enabled cycles.
- R5: `tc_out` is the registered zero detect. It goes high on the enabled clock edge at which the counter holds zero, and it stays high for exactly one cycle per period when N is greater than zero.
- R6: While `cnt_en` is low, the counter, the state and `tc_out` all hold.
- R7: Loading the register that is not selected does not change the running division sequence.
- R8: When the selected word is zero, the counter reloads zero every cycle and `tc_out` stays high continuously (divide by one).
- R9: `word_sel` is sampled only at reload time. Toggling it while the counter is non-zero and restoring it before zero leaves the period unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable; low stalls the block |
| word_sel | input | 1 | Reload word choice: 0 = A, 1 = B |
| word_a | input | 8 | Divide word A bus |
| word_b | input | 8 | Divide word B bus |
| load_a | input | 1 | Load strobe for the word A register (transparent while high) |
| load_b | input | 1 | Load strobe for the word B register (transparent while high) |
| tc_out | output | 1 | Registered terminal-count pulse |

## Verification
The bench checks the pulse spacing for each word. It expects word 5 to give a gap of 6 and word 3 a gap of 4. A design with an off-by-one reload would give gaps of 5 or 7. A zero word must hold the output high, and a design that treated zero as 256 would pulse only once every 257 cycles. The bench toggles the select input in mid-count and writes the idle word during a run. A design that sampled the select input on every cycle, or that shared one holding register between the words, would shorten or stretch those periods. It also holds a strobe high across a reload to test transparency, and it stalls the enable in mid-count, where a design that kept counting would pulse early.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int DWC_WORD_W = 8;

    typedef enum logic {
        ST_TERM = 1'b0,
        ST_DOWN = 1'b1
    } dwc_state_e;

endpackage

// File: rtl/dwc_word_hold.sv
module dwc_word_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] bus_in,
    output logic [W-1:0] word_eff
);

    logic [W-1:0] held_q;

    // Capture on every edge the strobe is high; keep otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
        end else if (load) begin
            held_q <= bus_in;
        end
    end

    // Transparent path while the strobe is high.
    always_comb begin
        word_eff = load ? bus_in : held_q;
    end

endmodule

// File: rtl/dwc_down_core.sv
module dwc_down_core
    import dwc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] reload_val,
    output logic         at_zero,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] ONE = W'(1);

    dwc_state_e   state_q;
    dwc_state_e   state_nx;
    logic [W-1:0] count_nx;

    // Next-state and next-count decode.
    always_comb begin
        state_nx = state_q;
        count_nx = count;
        if (en) begin
            unique case (state_q)
                ST_TERM: begin
                    count_nx = reload_val;
                    state_nx = (reload_val == '0) ? ST_TERM : ST_DOWN;
                end
                ST_DOWN: begin
                    count_nx = count - ONE;
                    state_nx = (count == ONE) ? ST_TERM : ST_DOWN;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_TERM;
            count   <= '0;
        end else begin
            state_q <= state_nx;
            count   <= count_nx;
        end
    end

    // Outputs.
    always_comb begin
        at_zero = (state_q == ST_TERM);
    end

endmodule

// File: rtl/dwc_tc_retime.sv
module dwc_tc_retime (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic zero_in,
    output logic tc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q <= 1'b0;
        end else if (en) begin
            tc_q <= zero_in;
        end
    end

endmodule

// File: rtl/divword_counter.sv
module divword_counter
    import dwc_pkg::*;
#(
    parameter int WORD_W = DWC_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              word_sel,
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    input  logic              load_a,
    input  logic              load_b,
    output logic              tc_out
);

    localparam int N_WORDS = 2;

    logic [N_WORDS-1:0][WORD_W-1:0] bus_arr;
    logic [N_WORDS-1:0]             load_arr;
    logic [N_WORDS-1:0][WORD_W-1:0] word_eff;
    logic [WORD_W-1:0]              reload_word;
    logic [WORD_W-1:0]              count_q;
    logic                           zero_hit;

    always_comb begin
        bus_arr[0]  = word_a;
        bus_arr[1]  = word_b;
        load_arr[0] = load_a;
        load_arr[1] = load_b;
    end

    for (genvar g = 0; g < N_WORDS; g++) begin : g_hold
        dwc_word_hold #(.W(WORD_W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .load     (load_arr[g]),
            .bus_in   (bus_arr[g]),
            .word_eff (word_eff[g])
        );
    end

    always_comb begin
        reload_word = word_eff[word_sel];
    end

    dwc_down_core #(.W(WORD_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (cnt_en),
        .reload_val (reload_word),
        .at_zero    (zero_hit),
        .count      (count_q)
    );

    dwc_tc_retime u_retime (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .zero_in (zero_hit),
        .tc_q    (tc_out)
    );

endmodule

// File: rtl/dwc_checks.sv
module dwc_checks #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         load_a,
    input logic         at_zero,
    input logic [W-1:0] count,
    input logic [W-1:0] reload_val,
    input logic [W-1:0] eff_a,
    input logic         tc_out
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!tc_out && count == '0));

    p_hold_word_r2: assert property (@(posedge clk) disable iff (rst)
        !load_a |=> (load_a || $stable(eff_a)));

    p_reload_pick_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && at_zero) |=> (count == $past(reload_val)));

    p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !at_zero) |=> (count == $past(count) - W'(1)));

    p_tc_high_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && at_zero) |=> tc_out);

    p_tc_low_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !at_zero) |=> !tc_out);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(tc_out) && $stable(count)));

    p_zero_state_r8: assert property (@(posedge clk) disable iff (rst)
        at_zero == (count == '0));

endmodule

bind divword_counter dwc_checks #(.W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnt_en     (cnt_en),
    .load_a     (load_a),
    .at_zero    (zero_hit),
    .count      (count_q),
    .reload_val (reload_word),
    .eff_a      (word_eff[0]),
    .tc_out     (tc_out)
);

// File: tb/tb_divword_counter.sv
`timescale 1ns/1ps
module tb_divword_counter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       word_sel = 1'b0;
    logic [7:0] word_a = '0;
    logic [7:0] word_b = '0;
    logic       load_a = 1'b0;
    logic       load_b = 1'b0;
    logic       tc_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // Reference model state (from the requirements).
    logic [7:0] m_ha = '0, m_hb = '0, m_cnt = '0;
    logic       m_tc = 1'b0;

    always #10 clk = ~clk;

    divword_counter dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .word_sel(word_sel),
        .word_a(word_a), .word_b(word_b), .load_a(load_a), .load_b(load_b),
        .tc_out(tc_out)
    );

    function automatic logic [7:0] pick_reload(logic sel, logic la, logic lb,
                                               logic [7:0] a, logic [7:0] b,
                                               logic [7:0] ha, logic [7:0] hb);
        logic [7:0] ea = la ? a : ha;
        logic [7:0] eb = lb ? b : hb;
        return sel ? eb : ea;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: tc_out=%0b expected %0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // One clock: update the model at the edge, compare away from it.
    task automatic step(input string tag);
        logic [7:0] rel;
        @(posedge clk);
        cycles++;
        rel = pick_reload(word_sel, load_a, load_b, word_a, word_b, m_ha, m_hb);
        if (rst) begin
            m_cnt = '0; m_ha = '0; m_hb = '0; m_tc = 1'b0;
        end else begin
            if (load_a) m_ha = word_a;
            if (load_b) m_hb = word_b;
            if (cnt_en) begin
                m_tc = (m_cnt == 8'd0);
                m_cnt = (m_cnt == 8'd0) ? rel : m_cnt - 8'd1;
            end
        end
        @(negedge clk);
        check(tag, tc_out, m_tc);
    endtask

    task automatic wait_tc(input string tag);
        for (int i = 0; i < 600 && tc_out !== 1'b1; i++) step(tag);
    endtask

    task automatic gap_check(input int exp, input string tag, input bit do_chk);
        int k = 0;
        wait_tc(tag);
        step(tag);
        k = 1;
        if (do_chk && exp > 1) check({tag, " single-cycle pulse"}, tc_out, 1'b0);
        while (tc_out !== 1'b1 && k < 600) begin
            step(tag);
            k++;
        end
        if (do_chk) begin
            checks++;
            if (k != exp) begin
                errors++;
                $display("FAIL %s: period=%0d expected %0d", tag, k, exp);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        int k;
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        step("R1");
        step("R1");
        rst = 1'b0;
        check("R1 reset output low", tc_out, 1'b0);

        // Zero words after reset: divide by one.
        cnt_en = 1'b1;
        step("R8");
        check("R8 zero word high", tc_out, 1'b1);
        gap_check(1, "R8", 1);
        gap_check(1, "R8", 1);

        // Load A = 5, then scramble the bus.
        word_a = 8'd5; load_a = 1'b1;
        step("R2");
        load_a = 1'b0; word_a = 8'hEE;
        gap_check(6, "R4", 0);
        gap_check(6, "R4", 1);
        gap_check(6, "R5", 1);

        // Load the idle word B while A runs.
        word_b = 8'd3; load_b = 1'b1;
        step("R7");
        load_b = 1'b0; word_b = 8'h77;
        gap_check(6, "R7", 1);

        // Switch to B.
        word_sel = 1'b1;
        gap_check(4, "R3", 0);
        gap_check(4, "R3", 1);
        gap_check(4, "R3", 1);
        word_sel = 1'b0;
        gap_check(6, "R3", 0);
        gap_check(6, "R3", 1);

        // Select toggled mid-count only.
        wait_tc("R9");
        step("R9");
        word_sel = 1'b1;
        step("R9");
        step("R9");
        word_sel = 1'b0;
        k = 3;
        while (tc_out !== 1'b1 && k < 600) begin step("R9"); k++; end
        checks++;
        if (k != 6) begin errors++; $display("FAIL R9: period=%0d expected 6", k); end

        // Enable stall mid-count.
        wait_tc("R6");
        step("R6");
        step("R6");
        cnt_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step("R6");
            check("R6 stalled output", tc_out, 1'b0);
        end
        cnt_en = 1'b1;
        k = 7;
        while (tc_out !== 1'b1 && k < 600) begin step("R6"); k++; end
        checks++;
        if (k != 11) begin errors++; $display("FAIL R6: period=%0d expected 11", k); end

        // Transparency: strobe held high across a reload.
        wait_tc("R2");
        word_a = 8'd2; load_a = 1'b1;
        gap_check(6, "R2", 1);
        gap_check(3, "R2", 1);
        load_a = 1'b0; word_a = 8'd9;
        gap_check(3, "R2 hold", 1);

        // Constrained random phase.
        for (int i = 0; i < 3000; i++) begin
            cnt_en   = ($urandom_range(7) != 0);
            if ($urandom_range(31) == 0) word_sel = ~word_sel;
            load_a   = ($urandom_range(15) == 0);
            load_b   = ($urandom_range(15) == 0);
            word_a   = 8'($urandom_range(11));
            word_b   = 8'($urandom_range(11));
            rst      = ($urandom_range(499) == 0);
            step("R4 random");
        end
        rst = 1'b0; load_a = 1'b0; load_b = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule